// File: doc/BRIEF.md
# Privileged Trap-State Control Register File

A bank of privileged processor control registers reached through one register index and a single-cycle read/write port. Reads are combinational: the value of the selected register appears on `rdata_o` in the same cycle as the request. A write is committed at the next rising clock edge. The bank holds a trap-level register and five save slots kept once per trap level: saved PC, saved next PC, saved state, trap cause and saved hyper state. An access to a save slot is steered to the entry for the current trap level minus one.

Several registers shape the value they store or return. The processor-state register keeps only a fixed set of bits. The vector base register is aligned. The window pointer is clamped. The floating-point state register always reads with its two low bits set. The version register returns a constant built from the parameters.

The block also produces a packed translation-context word for the MMU, made from fields of several registers. It drives a trap-level-zero interrupt request that is updated on each legal trap-level write. Accesses that are not allowed raise `illegal_o` in the same cycle, and such a write changes nothing.

Top module: `trap_ctl_regfile`

## Requirements
- R1: The save-slot indices (1 saved PC, 2 saved next PC, 3 saved state, 4 trap cause, 5 saved hyper state) select the entry for trap level TL-1, for both read and write. A write to one level leaves the entries of every other level unchanged.
- R2: A write to the processor-state register (index 6) stores the written value AND 0x13DE, which keeps bits 1-4, 6-9 and 12.
- R3: A write to the vector base register (index 7) stores the value with bits 14:0 cleared.
- R4: A write to the window pointer (index 8) with a value greater than NWIN stores NWIN-1. Any other value is stored as written, so a write of exactly NWIN reads back NWIN.
- R5: After reset, the hyper state register (index 9) reads 0x800 and the strand status register (index 10) reads 0x50000. Every other stored register, the floating-point state's stored bits, and `tlz_irq_o` are zero.
- R6: On a legal write to the trap level, `tlz_irq_o` takes the value (new TL == 0) AND hyper-state bit 0 AND NOT hyper-state bit 2, starting from the next cycle. No other access changes it.
- R7: The context word `mmu_ctx_o` is laid out as follows. Bit 0 is hyper-state bit 2 and bit 1 is hyper-state bit 5. Bits 3:2 are processor-state bits 3:2. Bits 5:4 are LSU-control bits 3:2. Bits 15:8 are partition bits 7:0. Bits 18:16 are TL bits 2:0. Bits 47:32 are primary context bits 15:0 and bits 63:48 are secondary context bits 15:0. All other bits are zero. The same word is readable at index 17.
- R8: A read of index 11 returns 0x3E in bits 63:48, 0x23 in bits 47:32, 0x20 in bits 31:24, MAX_TL in bits 15:8, NWIN-1 in bits 7:0, and zero elsewhere.
- R9: A read of the floating-point state register (index 12) returns its stored value with bits 1:0 forced to 1.
- R10: `illegal_o` rises in the same cycle as a request that is not allowed. This covers a save-slot access while TL is 0 or greater than MAX_TL, any index above 17, and a write to index 11 or 17. Such a write changes no state.
- R11: Indices 0 (trap level), 10 (strand status), 13 (primary context), 14 (secondary context), 15 (partition), 16 (LSU control) and 9 (hyper state) read back the last value written, truncated to TLW bits for the trap level. A read returns the current value in the same cycle, and a write is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | 5 | Register index |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, same cycle |
| illegal_o | output | 1 | Current request not allowed |
| mmu_ctx_o | output | 64 | Packed translation-context word |
| tlz_irq_o | output | 1 | Trap-level-zero interrupt request |

## Verification
Results arrive at two times. `rdata_o`, `illegal_o` and `mmu_ctx_o` are combinational on the present request and state, so they are due in the same cycle. Every write, including its effect on `tlz_irq_o` and on the context word, shows up only after one rising edge. The bench drives each request just after a falling edge and compares all four outputs against its behavioural model one time unit later. It then advances the model at the rising edge, so every write effect is checked in the access that follows it.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;
  localparam int DW      = 64;
  localparam int IDXW    = 5;
  localparam int N_SAVE  = 5;

  typedef enum logic [IDXW-1:0] {
    IDX_TRAP_LVL  = 5'd0,
    IDX_SV_PC     = 5'd1,
    IDX_SV_NPC    = 5'd2,
    IDX_SV_STATE  = 5'd3,
    IDX_SV_CAUSE  = 5'd4,
    IDX_SV_HYP    = 5'd5,
    IDX_PROC_ST   = 5'd6,
    IDX_VEC_BASE  = 5'd7,
    IDX_WIN_PTR   = 5'd8,
    IDX_HYP_ST    = 5'd9,
    IDX_STRAND_ST = 5'd10,
    IDX_VERSION   = 5'd11,
    IDX_FP_ST     = 5'd12,
    IDX_CTX_PRI   = 5'd13,
    IDX_CTX_SEC   = 5'd14,
    IDX_PART      = 5'd15,
    IDX_LSU       = 5'd16,
    IDX_CTX_WORD  = 5'd17
  } reg_idx_e;

  localparam logic [DW-1:0] PROC_KEEP    = 64'h0000_0000_0000_13DE;
  localparam logic [DW-1:0] VEC_KEEP     = ~64'h0000_0000_0000_7FFF;
  localparam logic [DW-1:0] HYP_RST      = 64'h0000_0000_0000_0800;
  localparam logic [DW-1:0] STRAND_RST   = 64'h0000_0000_0005_0000;
endpackage

// File: rtl/trap_ctl_decode.sv
module trap_ctl_decode
  import trap_ctl_pkg::*;
#(
  parameter int MAX_TL = 6,
  localparam int TLW   = $clog2(MAX_TL + 1),
  localparam int LVLW  = (MAX_TL > 1) ? $clog2(MAX_TL) : 1,
  localparam int SLW   = $clog2(N_SAVE + 1)
) (
  input  logic            req_i,
  input  logic            we_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [TLW-1:0]  tl_i,
  output logic            is_save_o,
  output logic [SLW-1:0]  slot_o,
  output logic [LVLW-1:0] lvl_o,
  output logic            illegal_o,
  output logic            wr_ok_o
);
  logic unimpl, read_only, bad_lvl;
  logic [TLW-1:0] tl_m1;

  assign is_save_o = (idx_i >= IDX_SV_PC) && (idx_i <= IDX_SV_HYP);
  assign slot_o    = SLW'(idx_i - IDX_SV_PC);
  assign tl_m1     = tl_i - TLW'(1);
  assign lvl_o     = LVLW'(tl_m1);

  assign unimpl    = idx_i > IDX_CTX_WORD;
  assign read_only = (idx_i == IDX_VERSION) || (idx_i == IDX_CTX_WORD);
  assign bad_lvl   = (tl_i == '0) || (int'(tl_i) > MAX_TL);

  assign illegal_o = req_i && (unimpl || (is_save_o && bad_lvl) || (we_i && read_only));
  assign wr_ok_o   = req_i && we_i && !illegal_o;
endmodule

// File: rtl/trap_save_bank.sv
module trap_save_bank #(
  parameter int N_SLOTS = 5,
  parameter int DEPTH   = 6,
  parameter int DW      = 64,
  localparam int SLW    = $clog2(N_SLOTS + 1),
  localparam int LVLW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [SLW-1:0]  slot_i,
  input  logic [LVLW-1:0] lvl_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] bank_q [N_SLOTS][DEPTH];
  logic          in_range;

  assign in_range = (int'(slot_i) < N_SLOTS) && (int'(lvl_i) < DEPTH);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          bank_q[s][l] <= '0;
        else if (wr_i && slot_i == SLW'(s) && lvl_i == LVLW'(l))
          bank_q[s][l] <= wdata_i;
      end
    end
  end

  assign rdata_o = in_range ? bank_q[slot_i][lvl_i] : '0;

  p_bank_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_range) |=> (bank_q[$past(slot_i)][$past(lvl_i)] == $past(wdata_i)));
  p_bank_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && in_range) |=> (bank_q[$past(slot_i)][$past(lvl_i)]
                             == $past(bank_q[slot_i][lvl_i])));
endmodule

// File: rtl/trap_ctx_pack.sv
module trap_ctx_pack (
  input  logic [1:0]  hyp_bits_i,   // {bit5, bit2}
  input  logic [1:0]  proc_bits_i,  // bits 3:2
  input  logic [1:0]  lsu_bits_i,   // bits 3:2
  input  logic [7:0]  part_i,
  input  logic [2:0]  tl_i,
  input  logic [15:0] ctx_pri_i,
  input  logic [15:0] ctx_sec_i,
  output logic [63:0] ctx_o
);
  always_comb begin
    ctx_o        = '0;
    ctx_o[0]     = hyp_bits_i[0];
    ctx_o[1]     = hyp_bits_i[1];
    ctx_o[3:2]   = proc_bits_i;
    ctx_o[5:4]   = lsu_bits_i;
    ctx_o[15:8]  = part_i;
    ctx_o[18:16] = tl_i;
    ctx_o[47:32] = ctx_pri_i;
    ctx_o[63:48] = ctx_sec_i;
  end
endmodule

// File: rtl/trap_ctl_regfile.sv
module trap_ctl_regfile
  import trap_ctl_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int NWIN   = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  idx_i,
  input  logic [63:0] wdata_i,
  output logic [63:0] rdata_o,
  output logic        illegal_o,
  output logic [63:0] mmu_ctx_o,
  output logic        tlz_irq_o
);
  localparam int TLW  = $clog2(MAX_TL + 1);
  localparam int LVLW = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;
  localparam int SLW  = $clog2(N_SAVE + 1);
  localparam int WPW  = $clog2(NWIN + 1);
  localparam logic [DW-1:0] VERSION_WORD =
    {16'h003E, 16'h0023, 8'h20, 8'h00, 8'(MAX_TL), 8'(NWIN - 1)};

  logic [TLW-1:0]  tl_q;
  logic [WPW-1:0]  win_q;
  logic [DW-1:0]   proc_q, vec_q, hyp_q, strand_q, fp_q;
  logic [DW-1:0]   pri_q, sec_q, part_q, lsu_q;
  logic            tlz_q;

  logic            is_save, wr_ok;
  logic [SLW-1:0]  slot;
  logic [LVLW-1:0] lvl;
  logic [DW-1:0]   save_rdata;
  logic [TLW-1:0]  new_tl;
  logic [WPW-1:0]  win_next;
  logic [2:0]      tl3;

  trap_ctl_decode #(.MAX_TL(MAX_TL)) u_dec (
    .req_i, .we_i, .idx_i, .tl_i(tl_q),
    .is_save_o(is_save), .slot_o(slot), .lvl_o(lvl),
    .illegal_o, .wr_ok_o(wr_ok)
  );

  trap_save_bank #(.N_SLOTS(N_SAVE), .DEPTH(MAX_TL), .DW(DW)) u_bank (
    .clk_i, .rst_ni,
    .wr_i(wr_ok && is_save), .slot_i(slot), .lvl_i(lvl),
    .wdata_i, .rdata_o(save_rdata)
  );

  assign tl3 = 3'(tl_q);

  trap_ctx_pack u_pack (
    .hyp_bits_i({hyp_q[5], hyp_q[2]}), .proc_bits_i(proc_q[3:2]),
    .lsu_bits_i(lsu_q[3:2]), .part_i(part_q[7:0]), .tl_i(tl3),
    .ctx_pri_i(pri_q[15:0]), .ctx_sec_i(sec_q[15:0]), .ctx_o(mmu_ctx_o)
  );

  assign new_tl   = wdata_i[TLW-1:0];
  assign win_next = (wdata_i > DW'(NWIN)) ? WPW'(NWIN - 1) : wdata_i[WPW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tl_q <= '0;  win_q <= '0;  tlz_q <= 1'b0;
      proc_q <= '0;  vec_q <= '0;  hyp_q <= HYP_RST;  strand_q <= STRAND_RST;
      fp_q <= '0;  pri_q <= '0;  sec_q <= '0;  part_q <= '0;  lsu_q <= '0;
    end else if (wr_ok) begin
      unique case (idx_i)
        IDX_TRAP_LVL: begin
          tl_q  <= new_tl;
          tlz_q <= (new_tl == '0) && hyp_q[0] && !hyp_q[2];
        end
        IDX_PROC_ST:   proc_q   <= wdata_i & PROC_KEEP;
        IDX_VEC_BASE:  vec_q    <= wdata_i & VEC_KEEP;
        IDX_WIN_PTR:   win_q    <= win_next;
        IDX_HYP_ST:    hyp_q    <= wdata_i;
        IDX_STRAND_ST: strand_q <= wdata_i;
        IDX_FP_ST:     fp_q     <= wdata_i;
        IDX_CTX_PRI:   pri_q    <= wdata_i;
        IDX_CTX_SEC:   sec_q    <= wdata_i;
        IDX_PART:      part_q   <= wdata_i;
        IDX_LSU:       lsu_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && !illegal_o) begin
      if (is_save) rdata_o = save_rdata;
      else begin
        unique case (idx_i)
          IDX_TRAP_LVL:  rdata_o = DW'(tl_q);
          IDX_PROC_ST:   rdata_o = proc_q;
          IDX_VEC_BASE:  rdata_o = vec_q;
          IDX_WIN_PTR:   rdata_o = DW'(win_q);
          IDX_HYP_ST:    rdata_o = hyp_q;
          IDX_STRAND_ST: rdata_o = strand_q;
          IDX_VERSION:   rdata_o = VERSION_WORD;
          IDX_FP_ST:     rdata_o = fp_q | DW'(3);
          IDX_CTX_PRI:   rdata_o = pri_q;
          IDX_CTX_SEC:   rdata_o = sec_q;
          IDX_PART:      rdata_o = part_q;
          IDX_LSU:       rdata_o = lsu_q;
          IDX_CTX_WORD:  rdata_o = mmu_ctx_o;
          default:       rdata_o = '0;
        endcase
      end
    end
  end

  assign tlz_irq_o = tlz_q;

  p_proc_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_q & ~PROC_KEEP) == '0);
  p_vec_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_q[14:0] == '0);
  p_win_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(win_q) <= NWIN);
  p_tlz_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ok && idx_i == IDX_TRAP_LVL) |=> $stable(tlz_irq_o));
  p_fp_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && idx_i == IDX_FP_ST) |-> rdata_o[1:0] == 2'b11);
  p_illegal_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && we_i) |=> ($stable(mmu_ctx_o) && $stable(tlz_irq_o)));
  p_illegal_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !illegal_o);
endmodule

// File: tb/test_trap_ctl_regfile.sv
module test_trap_ctl_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int MAXTL = 6;
  localparam int NW    = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  idx_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o, mmu_ctx_o;
  logic        illegal_o, tlz_irq_o;

  int checks = 0, errors = 0;
  string tag_override = "";

  trap_ctl_regfile #(.MAX_TL(MAXTL), .NWIN(NW)) i_trap_ctl_regfile (
    .clk_i, .rst_ni, .req_i, .we_i, .idx_i, .wdata_i,
    .rdata_o, .illegal_o, .mmu_ctx_o, .tlz_irq_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural reference state
  logic [63:0] m_sv [5][MAXTL];
  int          m_tl, m_win;
  logic [63:0] m_proc, m_vec, m_hyp, m_strand, m_fp, m_pri, m_sec, m_part, m_lsu;
  bit          m_tlz;

  task automatic m_reset();
    foreach (m_sv[s, l]) m_sv[s][l] = '0;
    m_tl = 0; m_win = 0; m_tlz = 0;
    m_proc = '0; m_vec = '0; m_hyp = 64'h800; m_strand = 64'h50000;
    m_fp = '0; m_pri = '0; m_sec = '0; m_part = '0; m_lsu = '0;
  endtask

  function automatic bit m_ill(int idx, bit we);
    if (idx > 17) return 1;
    if (idx >= 1 && idx <= 5 && (m_tl == 0 || m_tl > MAXTL)) return 1;
    if (we && (idx == 11 || idx == 17)) return 1;
    return 0;
  endfunction

  function automatic logic [63:0] m_ctx();
    logic [2:0] t = 3'(m_tl);
    return {m_sec[15:0], m_pri[15:0], 13'b0, t, m_part[7:0], 2'b0,
            m_lsu[3:2], m_proc[3:2], m_hyp[5], m_hyp[2]};
  endfunction

  function automatic logic [63:0] m_read(int idx);
    case (idx)
      0: return 64'(m_tl);
      1, 2, 3, 4, 5: return m_sv[idx-1][m_tl-1];
      6: return m_proc;
      7: return m_vec;
      8: return 64'(m_win);
      9: return m_hyp;
      10: return m_strand;
      11: return {16'h3E, 16'h23, 8'h20, 8'h0, 8'(MAXTL), 8'(NW-1)};
      12: return m_fp | 64'h3;
      13: return m_pri;
      14: return m_sec;
      15: return m_part;
      16: return m_lsu;
      17: return m_ctx();
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(int idx);
    if (tag_override != "") return tag_override;
    case (idx)
      1, 2, 3, 4, 5: return "R1";
      6: return "R2";
      7: return "R3";
      8: return "R4";
      11: return "R8";
      12: return "R9";
      17: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic m_write(int idx, logic [63:0] wd);
    case (idx)
      0: begin
        m_tl = int'(wd & 64'h7);
        m_tlz = (m_tl == 0) && m_hyp[0] && !m_hyp[2];
      end
      1, 2, 3, 4, 5: m_sv[idx-1][m_tl-1] = wd;
      6: m_proc = wd & 64'h13DE;
      7: m_vec = wd & ~64'h7FFF;
      8: m_win = (wd > 64'(NW)) ? NW - 1 : int'(wd);
      9: m_hyp = wd;
      10: m_strand = wd;
      12: m_fp = wd;
      13: m_pri = wd;
      14: m_sec = wd;
      15: m_part = wd;
      16: m_lsu = wd;
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic op(bit req, bit we, int idx, logic [63:0] wd);
    bit exp_ill;
    req_i = req; we_i = we; idx_i = 5'(idx); wdata_i = wd;
    #1;
    exp_ill = req && m_ill(idx, we);
    check("R10", 64'(illegal_o), 64'(exp_ill));
    if (req && !we && !exp_ill) check(tag_of(idx), rdata_o, m_read(idx));
    check("R7", mmu_ctx_o, m_ctx());
    check("R6", 64'(tlz_irq_o), 64'(m_tlz));
    @(posedge clk_i);
    if (req && we && !exp_ill) m_write(idx, wd);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(int idx); op(1, 0, idx, '0); endtask
  task automatic wr(int idx, logic [63:0] wd); op(1, 1, idx, wd); endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5: reset values
    tag_override = "R5";
    for (int i = 0; i < 18; i++) rd(i);
    tag_override = "";

    // R10: save slot with TL=0, unimplemented, read-only writes
    rd(1);
    wr(3, 64'hDEAD);
    wr(11, 64'h1234);
    wr(17, '1);
    wr(20, '1);
    rd(31);
    rd(11);  // R8

    // R1: banked save slots per level
    wr(0, 64'd3);
    for (int s = 1; s <= 5; s++) wr(s, 64'hA000 + 64'(s));
    wr(0, 64'd1);
    for (int s = 1; s <= 5; s++) wr(s, 64'hB000 + 64'(s));
    for (int s = 1; s <= 5; s++) rd(s);
    wr(0, 64'd3);
    for (int s = 1; s <= 5; s++) rd(s);
    wr(0, 64'd6);
    wr(2, 64'hFFFF_0000_1111_2222);
    rd(2);
    wr(0, 64'd7);  // TL above MAX_TL
    rd(1);
    wr(4, 64'h55);

    // R2, R3, R4
    wr(6, '1); rd(6);
    wr(7, '1); rd(7);
    wr(8, 64'd5); rd(8);
    wr(8, 64'd8); rd(8);
    wr(8, 64'd9); rd(8);
    wr(8, 64'hFFFF_FFFF_0000_0003); rd(8);

    // R6: trap-level-zero interrupt
    wr(9, 64'h1); wr(0, 64'd0); rd(0);
    wr(9, 64'h0); rd(9);          // not a TL write: must hold
    wr(0, 64'd2); rd(0);
    wr(9, 64'h5); wr(0, 64'd0); rd(0);
    wr(9, 64'h21); wr(0, 64'd0); rd(0);
    wr(0, 64'd1); rd(0);

    // R7, R9, R11
    wr(13, 64'h1234_5678_9ABC_DEF0);
    wr(14, 64'h0F0F_0F0F_0F0F_BEEF);
    wr(15, 64'h0000_0000_0000_03A5);
    wr(16, 64'h0000_0000_0000_000C);
    wr(6, 64'h0000_0000_0000_000C);
    wr(9, 64'h24);
    rd(17);
    wr(12, 64'h0); rd(12);
    wr(12, 64'hF0); rd(12);
    wr(10, 64'hCAFE); rd(10);

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      int idx = int'($urandom_range(0, 19));
      bit req = ($urandom_range(0, 9) != 0);
      bit we  = $urandom_range(0, 1) == 1;
      logic [63:0] wd = {$urandom, $urandom};
      if (idx == 0) wd = 64'($urandom_range(0, 7));
      if (idx == 9) wd = 64'($urandom_range(0, 63));
      op(req, we, idx, wd);
    end

    finish_run();
  end
endmodule